// File: doc/BRIEF.md
# Speculative Thread Order Controller

This block keeps the speculation order of the threads that a group of cores runs in parallel, where each thread is one iteration of a loop. At any moment exactly one core holds the non-speculative head position (rank 0). Every other core holds a distinct higher rank, and a higher rank means a later iteration. The controller tells the write buffer bank which core may drain its buffered stores and when. It restarts a core and every core later than it when a dependence violation is reported. It also tells every core which iteration number it is running.

A region starts with a single start pulse. Core k then runs iteration k at rank k. A core raises its finish line when its thread is done. Only the head may commit. A finished non-head thread is remembered and commits once it reaches rank 0. After a commit, the committing core takes the next unassigned iteration and becomes the most speculative thread, and every other core moves one rank closer to the head. The region ends when the head core raises its stop line. All outputs are registered, so every response appears one clock after the inputs that cause it. All pins are plain control pins with no handshake.

Top module: `spec_order_ctrl`

## Requirements
- R1: After reset the region is inactive, all pulse outputs are low, and core k reports rank k and iteration k.
- R2: A start pulse while inactive makes the region active on the next clock, with core k at rank k and iteration k. A start pulse while active is ignored.
- R3: When the head (rank 0) core finishes, or has already finished, and no violation is reported that cycle, a one-cycle commit pulse is raised for that core only, one clock later.
- R4: A finish from a non-head core does not commit it. The finish is held and commits in the first cycle in which that core is head, so commits appear at most one per cycle and in iteration order.
- R5: On a commit, the committing core moves to rank NCORE-1 and takes an iteration number one above the highest already assigned. Every other core's rank drops by one. Ranks always form a permutation with a single rank-0 core.
- R6: A violation from a core raises restart and flush pulses for that core and every core of higher rank. Ranks and iterations stay unchanged, and the held finishes of those cores are cleared.
- R7: When several cores report violations in the same cycle, the one of lowest rank decides which cores are restarted.
- R8: In a cycle with any violation, no commit occurs. A head finish that is not squashed stays held and commits on a later cycle.
- R9: A stop from the head core with no violation commits the head, flushes every other core and deactivates the region. A stop from a non-head core is ignored.
- R10: While the region is inactive, finish, violation and stop inputs are ignored.
- R11: The commit output is never more than one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| region_go_i | input | 1 | Start of a speculative region |
| done_i | input | NCORE | Per-core thread finished |
| viol_i | input | NCORE | Per-core dependence violation detected |
| stop_i | input | NCORE | Per-core end-of-region marker |
| active_o | output | 1 | Region in progress |
| rank_o | output | NCORE*RW | Per-core speculation rank, 0 = head, core k in bits [k*RW +: RW] |
| iter_o | output | NCORE*IW | Per-core iteration number, core k in bits [k*IW +: IW] |
| commit_o | output | NCORE | One-cycle commit enable to a core's write buffer |
| flush_o | output | NCORE | One-cycle flash-clear of a core's speculative state |
| restart_o | output | NCORE | One-cycle restart of a core's thread |

## Verification
The bench goes after finishes that arrive out of order. A design that commits a non-head thread early, or drops a held finish, would produce commit pulses out of iteration order or stall the ring. It also drives simultaneous violators at different ranks: taking the wrong violator restarts too few or too many cores. It tests a violation that coincides with a head finish, where a wrong design either commits through the violation or loses the finish. Finally, it sends stop markers from non-head cores, which a careless design would accept and use to end the region early.

// File: rtl/sto_pkg.sv
package sto_pkg;
  typedef enum logic {
    RG_IDLE = 1'b0,
    RG_RUN  = 1'b1
  } region_e;

  function automatic int unsigned rank_bits(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/sto_viol_pick.sv
module sto_viol_pick #(
  parameter int NCORE = 4,
  parameter int RW    = 2
) (
  input  logic [NCORE-1:0]    viol_i,
  input  logic                active_i,
  input  logic [NCORE*RW-1:0] rank_i,
  output logic                found_o,
  output logic [RW-1:0]       vrank_o
);
  // lowest rank among the violating cores decides the squash boundary
  always_comb begin
    found_o = 1'b0;
    vrank_o = '1;
    for (int c = 0; c < NCORE; c++) begin
      if (active_i && viol_i[c] && (!found_o || rank_i[c*RW +: RW] < vrank_o)) begin
        found_o = 1'b1;
        vrank_o = rank_i[c*RW +: RW];
      end
    end
  end
endmodule

// File: rtl/sto_slot.sv
module sto_slot #(
  parameter int NCORE = 4,
  parameter int RW    = 2,
  parameter int IW    = 16,
  parameter int IDX   = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          adv_i,
  input  logic          is_head_i,
  input  logic          clr_i,
  input  logic          done_i,
  input  logic [IW-1:0] next_iter_i,
  output logic [RW-1:0] rank_o,
  output logic [IW-1:0] iter_o,
  output logic          pend_o
);
  localparam logic [RW-1:0] TAIL = RW'(NCORE - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || start_i) begin
      rank_o <= RW'(IDX);
      iter_o <= IW'(IDX);
      pend_o <= 1'b0;
    end else if (clr_i) begin
      pend_o <= 1'b0;
    end else if (adv_i && is_head_i) begin
      rank_o <= TAIL;
      iter_o <= next_iter_i;
      pend_o <= 1'b0;
    end else if (adv_i) begin
      rank_o <= rank_o - 1'b1;
      pend_o <= pend_o | done_i;
    end else begin
      pend_o <= pend_o | done_i;
    end
  end

  // a finished thread stays held until it commits or is squashed
  AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !is_head_i && !clr_i && !start_i) |=> pend_o) else $error("held finish lost"); // R4
endmodule

// File: rtl/spec_order_ctrl.sv
module spec_order_ctrl #(
  parameter int NCORE = 4,
  parameter int IW    = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            region_go_i,
  input  logic [NCORE-1:0]                done_i,
  input  logic [NCORE-1:0]                viol_i,
  input  logic [NCORE-1:0]                stop_i,
  output logic                            active_o,
  output logic [NCORE*sto_pkg::rank_bits(NCORE)-1:0] rank_o,
  output logic [NCORE*IW-1:0]             iter_o,
  output logic [NCORE-1:0]                commit_o,
  output logic [NCORE-1:0]                flush_o,
  output logic [NCORE-1:0]                restart_o
);
  import sto_pkg::*;
  localparam int RW = rank_bits(NCORE);
  localparam logic [RW-1:0] TAIL = RW'(NCORE - 1);

  region_e            state_q;
  logic [IW-1:0]      next_iter_q;
  logic [NCORE-1:0]   head_vec, tail_vec, pend_vec, squash_vec;
  logic [RW-1:0]      rk [NCORE];
  logic               found;
  logic [RW-1:0]      vrank;
  logic               active, begin_ok, end_ok, head_ready, commit_adv;

  assign active = (state_q == RG_RUN);

  sto_viol_pick #(.NCORE(NCORE), .RW(RW)) u_pick (
    .viol_i(viol_i), .active_i(active), .rank_i(rank_o),
    .found_o(found), .vrank_o(vrank)
  );

  for (genvar c = 0; c < NCORE; c++) begin : g_slot
    assign rk[c]         = rank_o[c*RW +: RW];
    assign head_vec[c]   = (rk[c] == '0);
    assign tail_vec[c]   = (rk[c] == TAIL);
    assign squash_vec[c] = found && (rk[c] >= vrank);

    sto_slot #(.NCORE(NCORE), .RW(RW), .IW(IW), .IDX(c)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .start_i(begin_ok),
      .adv_i(commit_adv),
      .is_head_i(head_vec[c]),
      .clr_i(squash_vec[c] || end_ok),
      .done_i(done_i[c] && active),
      .next_iter_i(next_iter_q),
      .rank_o(rank_o[c*RW +: RW]),
      .iter_o(iter_o[c*IW +: IW]),
      .pend_o(pend_vec[c])
    );
  end

  assign begin_ok   = !active && region_go_i;
  assign end_ok     = active && !found && |(stop_i & head_vec);
  assign head_ready = |(head_vec & (done_i | pend_vec));
  assign commit_adv = active && !found && !end_ok && head_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= RG_IDLE;
      next_iter_q <= IW'(NCORE);
      commit_o    <= '0;
      flush_o     <= '0;
      restart_o   <= '0;
    end else begin
      if (begin_ok)    state_q <= RG_RUN;
      else if (end_ok) state_q <= RG_IDLE;

      if (begin_ok)        next_iter_q <= IW'(NCORE);
      else if (commit_adv) next_iter_q <= next_iter_q + 1'b1;

      commit_o  <= (commit_adv || end_ok) ? head_vec : '0;
      flush_o   <= squash_vec | (end_ok ? ~head_vec : '0);
      restart_o <= squash_vec;
    end
  end

  assign active_o = active;

  AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(commit_o)) else $error("commit not one-hot"); // R11
  AST_HEAD_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(head_vec) == 1) else $error("head not unique"); // R5
  AST_COMMIT_FROM_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_o != '0) |-> ((commit_o & ~$past(head_vec)) == '0)) else $error("commit from non-head"); // R3
  AST_COMMIT_TO_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_o != '0 && active_o) |-> ((commit_o & tail_vec) == commit_o)) else $error("committer not at tail"); // R5
  AST_SQUASH_KEEPS_RANKS: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_o != '0) |-> $stable(rank_o)) else $error("ranks moved on restart"); // R6
  AST_NO_COMMIT_ON_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_o != '0) |-> (commit_o == '0)) else $error("commit during violation"); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_o && !$past(active_o)) |-> (commit_o == '0 && restart_o == '0)) else $error("activity while idle"); // R10

  for (genvar a = 0; a < NCORE; a++) begin : g_tail_a
    for (genvar b = 0; b < NCORE; b++) begin : g_tail_b
      AST_RESTART_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_o[a] && rk[b] > rk[a]) |-> restart_o[b]) else $error("later thread not restarted"); // R6
    end
  end
endmodule

// File: tb/spec_order_ctrl_tb_top.sv
module spec_order_ctrl_tb_top;
  localparam int N  = 4;
  localparam int RW = 2;
  localparam int IW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic region_go_i = 1'b0;
  logic [N-1:0] done_i = '0, viol_i = '0, stop_i = '0;
  logic active_o;
  logic [N*RW-1:0] rank_o;
  logic [N*IW-1:0] iter_o;
  logic [N-1:0] commit_o, flush_o, restart_o;

  always #4 clk = ~clk;

  spec_order_ctrl #(.NCORE(N), .IW(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .region_go_i(region_go_i),
    .done_i(done_i), .viol_i(viol_i), .stop_i(stop_i),
    .active_o(active_o), .rank_o(rank_o), .iter_o(iter_o),
    .commit_o(commit_o), .flush_o(flush_o), .restart_o(restart_o)
  );

  int nchk = 0, nfail = 0;
  int mr[N], mi[N], mp[N];
  int mact, mnext, ec, ef, er;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int k = 0; k < N; k++) begin mr[k] = k; mi[k] = k; mp[k] = 0; end
    mact = 0; mnext = N; ec = 0; ef = 0; er = 0;
  endfunction

  function automatic void model_step(input int b, input int d, input int v, input int e);
    int vmin, h;
    ec = 0; ef = 0; er = 0;
    if (mact == 0) begin
      if (b != 0) begin
        mact = 1; mnext = N;
        for (int k = 0; k < N; k++) begin mr[k] = k; mi[k] = k; mp[k] = 0; end
      end
      return;
    end
    vmin = 99; h = 0;
    for (int k = 0; k < N; k++) begin
      if (v[k] && mr[k] < vmin) vmin = mr[k];
      if (mr[k] == 0) h = k;
    end
    if (vmin != 99) begin
      for (int k = 0; k < N; k++) begin
        if (mr[k] >= vmin) begin er |= (1 << k); mp[k] = 0; end
        else if (d[k]) mp[k] = 1;
      end
      ef = er;
      return;
    end
    if (e[h]) begin
      ec = 1 << h; ef = (~ec) & ((1 << N) - 1); mact = 0;
      for (int k = 0; k < N; k++) mp[k] = 0;
      return;
    end
    if (d[h] || mp[h] != 0) begin
      ec = 1 << h;
      for (int k = 0; k < N; k++) if (k != h) begin
        mr[k] = mr[k] - 1;
        if (d[k]) mp[k] = 1;
      end
      mr[h] = N - 1; mi[h] = mnext; mnext++; mp[h] = 0;
      return;
    end
    for (int k = 0; k < N; k++) if (d[k]) mp[k] = 1;
  endfunction

  task automatic compare_all();
    int cc;
    chk("R3 commit pulse", int'(commit_o), ec);
    chk("R6 flush pulse", int'(flush_o), ef);
    chk("R6 restart pulse", int'(restart_o), er);
    chk("R9 active", int'(active_o), mact);
    for (int k = 0; k < N; k++) begin
      chk("R5 rank", int'(rank_o[k*RW +: RW]), mr[k]);
      chk("R5 iteration", int'(iter_o[k*IW +: IW]), mi[k]);
    end
    cc = $countones(commit_o);
    chk("R11 commit one-hot", int'(cc <= 1), 1);
  endtask

  task automatic cyc(input int b, input int d, input int v, input int e);
    region_go_i = b[0]; done_i = d[N-1:0]; viol_i = v[N-1:0]; stop_i = e[N-1:0];
    model_step(b, d, v, e);
    @(posedge clk); #1;
    region_go_i = 1'b0; done_i = '0; viol_i = '0; stop_i = '0;
    compare_all();
  endtask

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk("R1 active after reset", int'(active_o), 0);
    chk("R1 commit after reset", int'(commit_o), 0);
    chk("R1 rank core3", int'(rank_o[3*RW +: RW]), 3);
    chk("R1 iteration core2", int'(iter_o[2*IW +: IW]), 2);

    cyc(0, 4'hF, 4'hF, 4'hF);
    chk("R10 no commit while idle", int'(commit_o), 0);
    chk("R10 no restart while idle", int'(restart_o), 0);
    cyc(1, 0, 0, 0);
    chk("R2 active after start", int'(active_o), 1);
    chk("R2 rank core2", int'(rank_o[2*RW +: RW]), 2);
    cyc(1, 0, 0, 0);
    chk("R2 start ignored while active", int'(iter_o[1*IW +: IW]), 1);
    cyc(0, 4'b0100, 0, 0);
    chk("R4 non-head finish holds", int'(commit_o), 0);
    cyc(0, 4'b0010, 0, 0);
    chk("R4 non-head finish holds", int'(commit_o), 0);
    cyc(0, 4'b0001, 0, 0);
    chk("R3 head commit", int'(commit_o), 1);
    chk("R5 committer to tail", int'(rank_o[0 +: RW]), 3);
    chk("R5 next iteration", int'(iter_o[0 +: IW]), 4);
    cyc(0, 0, 0, 0);
    chk("R4 held finish commits in order", int'(commit_o), 2);
    cyc(0, 0, 0, 0);
    chk("R4 held finish commits in order", int'(commit_o), 4);
    // ranks now c0=1 c1=2 c2=3 c3=0
    cyc(0, 0, 4'b0011, 0);
    chk("R7 lowest-rank violator decides", int'(restart_o), 4'b0111);
    cyc(0, 4'b1000, 4'b0100, 0);
    chk("R8 no commit during violation", int'(commit_o), 0);
    chk("R8 only later thread restarted", int'(restart_o), 4'b0100);
    cyc(0, 0, 0, 0);
    chk("R8 held head finish commits", int'(commit_o), 4'b1000);
    // ranks now c0=0 c1=1 c2=2 c3=3
    cyc(0, 0, 0, 4'b0010);
    chk("R9 stop from non-head ignored", int'(active_o), 1);
    chk("R9 stop from non-head no flush", int'(flush_o), 0);
    cyc(0, 0, 0, 4'b0001);
    chk("R9 stop commits head", int'(commit_o), 1);
    chk("R9 stop flushes others", int'(flush_o), 4'b1110);
    chk("R9 stop deactivates", int'(active_o), 0);

    void'($urandom(32'd1234));
    for (int t = 0; t < 4000; t++) begin
      int b, d, v, e;
      b = ($urandom % 4 == 0);
      d = 0; v = 0; e = 0;
      for (int k = 0; k < N; k++) begin
        if ($urandom % 10 < 3) d |= (1 << k);
        if ($urandom % 40 == 0) v |= (1 << k);
        if ($urandom % 60 == 0) e |= (1 << k);
      end
      cyc(b, d, v, e);
    end

    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule